// File: doc/BRIEF.md
# Cascaded 8b/10b Symbol Encoder with Disparity Override

This block turns bytes into 8b/10b code groups, one byte per clock in single-width mode or two bytes per clock in double-width mode. Each byte has a control flag that asks for a special (K) code instead of a data (D) code. Code selection follows the IEEE 802.3 8b/10b definition, built from a 5b/6b and a 3b/4b sub-block. In double-width mode the two symbol encoders are chained. The high byte is encoded with the running disparity left by the low byte in the same cycle, so the whole 20-bit word is DC-balanced as if it had been encoded one symbol at a time.

The running disparity starts negative after reset. It is kept across cycles and changes only on cycles that carry a valid input. An override pair lets the user force the disparity that encoding starts from. A control flag on a byte that is not one of the twelve legal K codes raises a per-lane error flag, and the lane emits the D code for that byte. The result is registered with one cycle of latency.

Top module: `cascade_8b10b_enc`

## Requirements
- R1: While reset is held and after it is released, `code_valid` is 0, `code_out` is 0 and `rd_out` is 0 (negative). The first code group is taken from the negative-disparity column, for example K.28.5 (byte 0xBC, control 1) gives 001111 1010 in abcdei fghj order.
- R2: Each 10-bit lane field carries, from bit 9 down to bit 0, the code bits j, h, g, f, i, e, d, c, b, a. Bit a is at bit 0 and is sent first.
- R3: A byte with control 0 is encoded as the IEEE 802.3 D.x.y code for the current disparity, where x is byte bits 4..0 and y is byte bits 7..5. Every emitted group has 4, 5 or 6 ones.
- R4: When `force_disp` is 1 on a valid cycle, encoding starts from the disparity given by `force_val` (1 = positive, 0 = negative) instead of the stored one.
- R5: The running disparity flips after a group with 6 or 4 ones and is unchanged after a group with 5 ones. A group with 6 ones appears only from negative disparity, and a group with 4 ones only from positive disparity.
- R6: A control 1 on one of the twelve legal K bytes (K.28.0 to K.28.7 and K.23.7, K.27.7, K.29.7, K.30.7) gives the K code, for example K.28.1 from positive disparity gives 110000 0110.
- R7: A control 1 on any other byte sets that lane's `kerr_out` bit and emits the D code of the byte.
- R8: On cycles with `in_valid` 0, `rd_out`, `code_out` and `kerr_out` hold their values, `code_valid` is 0 the next cycle, and `force_disp` has no effect.
- R9: In double-width mode the low byte (`in_data[7:0]`, `in_ctrl[0]`) goes to `code_out[9:0]` and the high byte goes to `code_out[19:10]`. The high byte uses the disparity after the low symbol, and the disparity after the high symbol is stored.
- R10: In single-width mode only lane 0 is encoded. `code_out[19:10]` and `kerr_out[1]` are 0, and the disparity after lane 0 is stored.
- R11: The alternate 3b/4b code (0111 from negative, 1000 from positive) is used for D.x.7 when x is 17, 18 or 20 at negative disparity, or 11, 13 or 14 at positive disparity, and for every K code with y = 7.
- R12: The outputs change on the clock edge that samples a valid input, one cycle of latency, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bytes are valid this cycle |
| wide_mode | input | 1 | 1 = two bytes per cycle, 0 = one byte |
| in_data | input | LANES*8 | Bytes, lane 0 in the low bits |
| in_ctrl | input | LANES | Per-byte K-code request |
| force_disp | input | 1 | Use `force_val` as the starting disparity |
| force_val | input | 1 | Forced disparity, 1 = positive |
| code_out | output | LANES*10 | Registered code groups |
| kerr_out | output | LANES | Registered illegal K request flags |
| code_valid | output | 1 | `code_out` was updated by the last edge |
| rd_out | output | 1 | Stored running disparity, 1 = positive |

## Verification
A wrong stored disparity shows at the next valid cycle. Every unbalanced code after it comes from the wrong column, so a K.28.5 or D.0.0 gives the bitwise-complement pattern right away. A broken link between the two lanes shows only on the upper 10 bits of a double-width word whose low symbol is unbalanced. The bench therefore chains unbalanced low symbols and checks the upper field and `rd_out` in that same cycle. A wrong alternate-code choice or a wrong K.28 balanced-code inversion changes a single 3b/4b nibble, and the directed rows catch it on the cycle after it is driven.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  localparam int SYM_W = 8;
  localparam int GRP_W = 10;

  typedef struct packed {
    logic [GRP_W-1:0] code;
    logic             rd_after;
    logic             kbad;
  } sym_res_t;

  // 5b/6b sub-block, negative column, bit order a b c d e i (a in bit 5)
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // 3b/4b sub-block, negative column, bit order f g h j (f in bit 3)
  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt);
    logic [3:0] r;
    case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = alt ? 4'b0111 : 4'b1110;
    endcase
    return r;
  endfunction

  function automatic logic legal_k(input logic [SYM_W-1:0] b);
    logic [4:0] x;
    x = b[4:0];
    return (x == 5'd28) ||
           ((b[7:5] == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction

  function automatic logic want_alt(input logic [4:0] x, input logic rd6);
    return (!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14));
  endfunction

  // Encode one symbol; rd: 1 = positive
  function automatic sym_res_t encode_sym(input logic [SYM_W-1:0] b,
                                          input logic k, input logic rd_in);
    sym_res_t   res;
    logic [4:0] x;
    logic [2:0] y;
    logic       kok, k28, flip6, rd6, alt, bal4;
    logic [5:0] s6;
    logic [3:0] s4;
    x     = b[4:0];
    y     = b[7:5];
    kok   = k && legal_k(b);
    k28   = kok && (x == 5'd28);
    s6    = k28 ? 6'b001111 : six_neg(x);
    flip6 = ($countones(s6) != 3);
    if (rd_in && (flip6 || (x == 5'd7 && !k28))) s6 = ~s6;
    rd6   = rd_in ^ flip6;
    alt   = (y == 3'd7) && (kok || want_alt(x, rd6));
    s4    = four_neg(y, alt);
    bal4  = ($countones(s4) == 2);
    if (rd6 && (!bal4 || y == 3'd3)) s4 = ~s4;
    if (k28 && bal4 && y != 3'd3 && !rd6) s4 = ~s4;
    // bit 9..0 = j h g f i e d c b a
    res.code     = {s4[0], s4[1], s4[2], s4[3],
                    s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
    res.rd_after = rd6 ^ !bal4;
    res.kbad     = k && !kok;
    return res;
  endfunction

endpackage

// File: rtl/edc_lane.sv
module edc_lane
  import enc8b10b_pkg::*;
(
  input  logic [SYM_W-1:0] byte_in,
  input  logic             ctrl_in,
  input  logic             rd_in,
  output logic [GRP_W-1:0] code_o,
  output logic             rd_o,
  output logic             kerr_o
);

  sym_res_t res;
  int       ones_cnt;
  logic     unbal;

  always_comb begin
    res      = encode_sym(byte_in, ctrl_in, rd_in);
    code_o   = res.code;
    rd_o     = res.rd_after;
    kerr_o   = res.kbad;
    ones_cnt = $countones(res.code);
    unbal    = (ones_cnt != 5);
  end

  always_comb begin
    AST_GROUP_WEIGHT: assert (ones_cnt >= 4 && ones_cnt <= 6); // R3
    AST_HEAVY_FROM_NEG: assert (!(ones_cnt == 6) || !rd_in); // R5
    AST_LIGHT_FROM_POS: assert (!(ones_cnt == 4) || rd_in); // R5
    AST_RD_FLIP_RULE: assert (rd_o == (rd_in ^ unbal)); // R5
  end

endmodule

// File: rtl/edc_out_stage.sv
module edc_out_stage #(
  parameter int LANES = 2,
  parameter int GW    = 10,
  localparam int CW   = LANES * GW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CW-1:0]    codes_in,
  input  logic [LANES-1:0] kerr_in,
  input  logic             rd_next,
  output logic [CW-1:0]    code_q,
  output logic [LANES-1:0] kerr_q,
  output logic             valid_q,
  output logic             rd_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      kerr_q  <= '0;
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        code_q <= codes_in;
        kerr_q <= kerr_in;
        rd_q   <= rd_next;
      end
    end
  end

  AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> rd_q == $past(rd_q)); // R8
  AST_CODE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(code_q) && $stable(kerr_q)); // R8
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> valid_q); // R12

endmodule

// File: rtl/cascade_8b10b_enc.sv
module cascade_8b10b_enc
  import enc8b10b_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DW   = LANES * SYM_W,
  localparam int CW   = LANES * GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             wide_mode,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_ctrl,
  input  logic             force_disp,
  input  logic             force_val,
  output logic [CW-1:0]    code_out,
  output logic [LANES-1:0] kerr_out,
  output logic             code_valid,
  output logic             rd_out
);

  logic [LANES:0]    rd_chain;
  logic [CW-1:0]     lane_codes;
  logic [LANES-1:0]  lane_kerr;
  logic [CW-1:0]     codes_masked;
  logic [LANES-1:0]  kerr_masked;
  logic              rd_start;
  logic              rd_next;

  assign rd_start    = force_disp ? force_val : rd_out;
  assign rd_chain[0] = rd_start;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_en;
    assign lane_en = wide_mode || (i == 0);

    edc_lane u_lane (
      .byte_in (in_data[i*SYM_W +: SYM_W]),
      .ctrl_in (in_ctrl[i]),
      .rd_in   (rd_chain[i]),
      .code_o  (lane_codes[i*GRP_W +: GRP_W]),
      .rd_o    (rd_chain[i+1]),
      .kerr_o  (lane_kerr[i])
    );

    assign codes_masked[i*GRP_W +: GRP_W] = lane_en ? lane_codes[i*GRP_W +: GRP_W] : '0;
    assign kerr_masked[i] = lane_en && lane_kerr[i];
  end

  assign rd_next = wide_mode ? rd_chain[LANES] : rd_chain[1];

  edc_out_stage #(.LANES(LANES), .GW(GRP_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .codes_in (codes_masked),
    .kerr_in  (kerr_masked),
    .rd_next  (rd_next),
    .code_q   (code_out),
    .kerr_q   (kerr_out),
    .valid_q  (code_valid),
    .rd_q     (rd_out)
  );

  AST_FORCE_START: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && force_disp && !wide_mode |=>
      rd_out == ($past(force_val) ^ ($countones(code_out[GRP_W-1:0]) != 5))); // R4
  AST_NO_STALE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && force_disp |=> rd_out == $past(rd_out)); // R8

  if (LANES > 1) begin : g_upper_chk
    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !wide_mode |=> code_out[CW-1:GRP_W] == '0 && kerr_out[LANES-1:1] == '0); // R10
  end

endmodule

// File: tb/cascade_8b10b_enc_tb_top.sv
module cascade_8b10b_enc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic       vld;
    logic       wide;
    logic       frc;
    logic       fval;
    logic [1:0] ctl;
    logic [15:0] dat;
    logic [9:0] hi;   // expected, abcdei fghj order (a in bit 9)
    logic [9:0] lo;
    logic       rd;
    logic [1:0] kerr;
  } vec_t;

  // Expected groups written in transmission order a..j
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h00BC,10'b0,10'b0011111010,1'b1,2'b00}, // R1 R6 K.28.5 neg
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h00BC,10'b0,10'b1100000101,1'b0,2'b00}, // R6 K.28.5 pos
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h0000,10'b0,10'b1001110100,1'b0,2'b00}, // R3 D.0.0
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h00B5,10'b0,10'b1010101010,1'b0,2'b00}, // R5 D.21.5
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h0007,10'b0,10'b1110001011,1'b1,2'b00}, // R3 D.7.0 neg
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h0007,10'b0,10'b0001110100,1'b0,2'b00}, // R3 D.7.0 pos
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h00F1,10'b0,10'b1000110111,1'b1,2'b00}, // R11 D.17.7
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h00EB,10'b0,10'b1101001000,1'b0,2'b00}, // R11 D.11.7
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h00E1,10'b0,10'b0111010001,1'b0,2'b00}, // R11 D.1.7 primary
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h0000,10'b0,10'b1001110100,1'b0,2'b01}, // R7 bad K
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h003C,10'b0,10'b0011111001,1'b1,2'b00}, // R6 K.28.1 neg
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h003C,10'b0,10'b1100000110,1'b0,2'b00}, // R6 K.28.1 pos
    '{1'b1,1'b0,1'b0,1'b0,2'b01,16'h00F7,10'b0,10'b1110101000,1'b0,2'b00}, // R6 K.23.7
    '{1'b1,1'b0,1'b1,1'b1,2'b00,16'h0000,10'b0,10'b0110001011,1'b1,2'b00}, // R4 force pos
    '{1'b1,1'b0,1'b1,1'b0,2'b01,16'h00BC,10'b0,10'b0011111010,1'b1,2'b00}, // R4 force neg
    '{1'b0,1'b0,1'b1,1'b0,2'b00,16'h0055,10'b0,10'b0011111010,1'b1,2'b00}, // R8 idle
    '{1'b1,1'b1,1'b0,1'b0,2'b10,16'hBC00,10'b1100000101,10'b0110001011,1'b0,2'b00}, // R9
    '{1'b1,1'b1,1'b0,1'b0,2'b11,16'hBCBC,10'b1100000101,10'b0011111010,1'b0,2'b00}, // R9
    '{1'b1,1'b1,1'b0,1'b0,2'b10,16'h0107,10'b1000101011,10'b1110001011,1'b1,2'b10}, // R9 R7
    '{1'b1,1'b1,1'b1,1'b0,2'b00,16'hEBF1,10'b1101001000,10'b1000110111,1'b0,2'b00}, // R9 R11
    '{1'b1,1'b0,1'b0,1'b0,2'b00,16'h0000,10'b0,10'b1001110100,1'b0,2'b00}  // R10 R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_ctrl = '0;
  logic        force_disp = 1'b0;
  logic        force_val = 1'b0;
  logic [19:0] code_out;
  logic [1:0]  kerr_out;
  logic        code_valid;
  logic        rd_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_8b10b_enc #(.LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_mode(wide_mode),
    .in_data(in_data), .in_ctrl(in_ctrl), .force_disp(force_disp),
    .force_val(force_val), .code_out(code_out), .kerr_out(kerr_out),
    .code_valid(code_valid), .rd_out(rd_out)
  );

  // transmission order a..j to port order j..a is a bit reversal (R2)
  function automatic logic [9:0] to_port(input logic [9:0] v);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = v[9-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic f, input logic fv,
                       input logic [1:0] c, input logic [15:0] d);
    in_valid = v; wide_mode = w; force_disp = f; force_val = fv;
    in_ctrl = c; in_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_rd;
    logic [23:0] exp_w;
    logic [23:0] act_w;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(code_valid == 0 && rd_out == 0 && code_out == 0, "R1 reset state",
          {code_valid, rd_out, code_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(code_valid == 0 && rd_out == 0, "R1 after release", {code_valid, rd_out}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = VECS[i];
      drive(t.vld, t.wide, t.frc, t.fval, t.ctl, t.dat);
      exp_w = {to_port(t.hi), to_port(t.lo), t.kerr, t.vld, t.rd};
      act_w = {code_out, kerr_out, code_valid, rd_out};
      check(act_w == exp_w, $sformatf("R2/R3/R9 vector %0d", i), act_w, exp_w);
    end

    // R3 R5 sweep of all data bytes, single width
    prev_rd = rd_out;
    for (int b = 0; b < 256; b++) begin
      int ones;
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 16'(b));
      ones = $countones(code_out[9:0]);
      check(ones >= 4 && ones <= 6 && rd_out == (prev_rd ^ (ones != 5)) &&
            !(ones == 6 && prev_rd) && !(ones == 4 && !prev_rd) && kerr_out == 0,
            "R3 R5 data sweep", {prev_rd, rd_out, code_out}, b);
      prev_rd = rd_out;
    end

    // R6 R7 sweep of all bytes with control set
    for (int b = 0; b < 256; b++) begin
      logic [4:0] x;
      logic kexp;
      int ones;
      x = 5'(b);
      kexp = !((x == 5'd28) ||
               (b >= 224 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 16'(b));
      ones = $countones(code_out[9:0]);
      check(kerr_out == {1'b0, kexp} && ones >= 4 && ones <= 6 &&
            rd_out == (prev_rd ^ (ones != 5)),
            "R6 R7 control sweep", {kerr_out, code_out}, {kexp, 8'(b)});
      prev_rd = rd_out;
    end

    // R12 latency: idle, then drive and look before the edge
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 16'h00BC); // K.28.5 from neg, rd -> pos
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000);
    in_valid = 1'b1; in_ctrl = 2'b00; in_data = 16'h0000; force_disp = 1'b0;
    #(CLK_PERIOD/4);
    check(code_valid == 0 && code_out[9:0] == to_port(10'b0011111010),
          "R12 no early change", {code_valid, code_out}, to_port(10'b0011111010));
    @(negedge clk);
    check(code_valid == 1 && code_out[9:0] == to_port(10'b0110001011) && rd_out == 1,
          "R12 one-cycle update", {code_valid, rd_out, code_out}, to_port(10'b0110001011));

    // R1 mid-run reset restores negative disparity
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(rd_out == 0 && code_valid == 0 && code_out == 0, "R1 mid-run reset",
          {rd_out, code_valid, code_out}, 0);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 16'h00BC);
    check(code_out[9:0] == to_port(10'b0011111010) && rd_out == 1, "R1 first group neg column",
          {rd_out, code_out}, {1'b1, to_port(10'b0011111010)});

    // R8 idle with force toggling leaves disparity alone
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 16'hBCBC);
    check(rd_out == 1 && code_valid == 0 && code_out[9:0] == to_port(10'b0011111010),
          "R8 idle force ignored", {rd_out, code_valid, code_out}, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule